// File: doc/BRIEF.md
# SPI CRC Error Interrupt Monitor

This block sits behind an SPI slave front end that reports, once per frame, whether the received frame failed its CRC check. It counts how many failing frames arrive back to back, and when that run reaches a programmable limit it raises a sticky error status bit. Software or a neighbouring block drops the bit again with a one-cycle clear strobe.

The status bit also drives an interrupt pin. The pin can be active high or active low. It can either follow the status bit (level signalling) or give a single-cycle pulse when the bit rises (edge signalling). A separate enable holds the pin at its inactive level. A second enable switches CRC checking off; while it is off, frames do not touch the failure run.

The status logic is a three-state machine. `ST_QUIET` means no error is flagged. The transition `go_raise` fires on a limit hit when no clear is present and moves to `ST_RAISE`, the first flagged cycle, which is the only state that produces the edge pulse. `go_hold` moves from `ST_RAISE` to `ST_HELD` when no clear arrives. `go_clear` returns to `ST_QUIET` from either flagged state on a clear strobe.

Top module: `crc_err_irq_mon`

## Requirements
- R1: After reset, the status bit is 0, the failure run is empty, and the IRQ pin is at its inactive level. With the default settings (enable off, active low) the pin reads 1.
- R2: The 2-bit limit code sets the number of consecutive failing frames needed: 0 needs 1, 1 needs 2, 2 needs 4 and 3 needs 8. The status bit is visible the cycle after the clock edge that samples the last needed failing frame, and not earlier.
- R3: A frame strobe with the fail flag low, while checking is enabled, empties the failure run.
- R4: While the CRC enable input is low, frame strobes leave the failure run unchanged, whether they pass or fail.
- R5: Once set, the status bit stays 1 until a clear strobe is sampled.
- R6: A clear strobe forces the status bit to 0 on the next cycle, even when a limit hit is sampled on the same edge.
- R7: The failure run saturates at the limit. After a clear, the next single failing frame sets the status bit again until a passing frame empties the run.
- R8: In level mode (`cfg_irq_level`=1), with the pin enabled, the pin is at its active level exactly while the status bit is 1.
- R9: In edge mode (`cfg_irq_level`=0), with the pin enabled, the pin is active for exactly one cycle, the first cycle the status bit reads 1. It stays inactive while the bit remains set.
- R10: With `cfg_irq_pol`=1 the active level is 1. With `cfg_irq_pol`=0 the active level is 0.
- R11: With `cfg_irq_en`=0 the pin stays at its inactive level (the inverse of `cfg_irq_pol`) whatever the status bit does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_done | input | 1 | One-cycle strobe marking the end of an SPI frame |
| crc_fail | input | 1 | CRC result of that frame, 1 means fail, qualified by frame_done |
| cfg_limit | input | 2 | Run-length code: 0/1/2/3 mean 1/2/4/8 frames |
| cfg_crc_en | input | 1 | 1 enables CRC error counting |
| cfg_irq_en | input | 1 | 1 enables the IRQ pin function |
| cfg_irq_pol | input | 1 | 1 makes the pin active high, 0 active low |
| cfg_irq_level | input | 1 | 1 selects level signalling, 0 selects edge pulse |
| status_clr | input | 1 | One-cycle strobe that clears the status bit |
| crc_err_status | output | 1 | Sticky CRC error status |
| irq_pin | output | 1 | Interrupt pin level |

## Verification
A failure run that has not been emptied or has not saturated shows up as a status bit that sets one frame too early or too late, so it surfaces on the first failing frame after the faulty state. A state machine stuck in `ST_RAISE`, or one that skips it, shows in edge mode as a pulse longer than one cycle or no pulse at all, on the cycle after the hit. The bench probes each limit code at the frame just before the threshold and at the threshold itself, and it probes clear against set on the same edge.

// File: rtl/crcmon_pkg.sv
package crcmon_pkg;
    // Width of the run-length code field
    localparam int unsigned LIM_CODE_W = 2;
    // Largest run that any code can select
    localparam int unsigned MAX_RUN    = 1 << ((1 << LIM_CODE_W) - 1);
    localparam int unsigned RUN_W      = $clog2(MAX_RUN + 1);

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_RAISE = 2'd1,
        ST_HELD  = 2'd2
    } stat_state_t;
endpackage

// File: rtl/crcmon_fail_counter.sv
module crcmon_fail_counter
    import crcmon_pkg::*;
#(
    parameter int unsigned CODE_W = LIM_CODE_W,
    parameter int unsigned CW     = RUN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic              crc_fail,
    input  logic              crc_en,
    input  logic [CODE_W-1:0] limit_code,
    output logic              hit
);
    localparam logic [CW:0] ONE_W = (CW+1)'(1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] run_d;
    logic [CW:0]   limit;
    logic [CW:0]   run_inc;
    logic          take;

    assign limit   = ONE_W << limit_code;
    assign run_inc = {1'b0, run_q} + ONE_W;
    assign take    = frame_done && crc_en;

    always_comb begin
        run_d = run_q;
        if (take) begin
            if (!crc_fail)
                run_d = '0;
            else if (run_inc >= limit)
                run_d = limit[CW-1:0];
            else
                run_d = run_inc[CW-1:0];
        end
    end

    assign hit = take && crc_fail && (run_inc >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R7
    run_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ({1'b0, run_q} <= $past(limit)));
    // R3
    run_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !crc_fail) |=> (run_q == '0));
    // R4
    run_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(run_q));
endmodule

// File: rtl/crcmon_status_fsm.sv
module crcmon_status_fsm
    import crcmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic status,
    output logic rise
);
    stat_state_t st_q;
    stat_state_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUIET: if (hit && !clr) st_d = ST_RAISE;   // go_raise
            ST_RAISE: st_d = clr ? ST_QUIET : ST_HELD;    // go_clear / go_hold
            ST_HELD:  if (clr) st_d = ST_QUIET;           // go_clear
            default:  st_d = ST_QUIET;
        endcase
    end

    always_comb begin
        status = 1'b0;
        rise   = 1'b0;
        unique case (st_q)
            ST_QUIET: ;
            ST_RAISE: begin status = 1'b1; rise = 1'b1; end
            ST_HELD:  status = 1'b1;
            default:  ;
        endcase
    end

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr) |=> status);
    // R6
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !status);
    // R9
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/crcmon_irq_drive.sv
module crcmon_irq_drive (
    input  logic status,
    input  logic rise,
    input  logic irq_en,
    input  logic irq_pol,
    input  logic irq_level,
    output logic pin
);
    logic active;

    assign active = irq_en && (irq_level ? status : rise);
    assign pin    = irq_pol ? active : !active;

    // R11
    always_comb begin
        if (!irq_en) idle_level_chk: assert (pin == !irq_pol);
    end
endmodule

// File: rtl/crc_err_irq_mon.sv
module crc_err_irq_mon
    import crcmon_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_done,
    input  logic                  crc_fail,
    input  logic [LIM_CODE_W-1:0] cfg_limit,
    input  logic                  cfg_crc_en,
    input  logic                  cfg_irq_en,
    input  logic                  cfg_irq_pol,
    input  logic                  cfg_irq_level,
    input  logic                  status_clr,
    output logic                  crc_err_status,
    output logic                  irq_pin
);
    logic hit;
    logic rise;

    crcmon_fail_counter u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .crc_fail   (crc_fail),
        .crc_en     (cfg_crc_en),
        .limit_code (cfg_limit),
        .hit        (hit)
    );

    crcmon_status_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .clr    (status_clr),
        .status (crc_err_status),
        .rise   (rise)
    );

    crcmon_irq_drive u_irq (
        .status    (crc_err_status),
        .rise      (rise),
        .irq_en    (cfg_irq_en),
        .irq_pol   (cfg_irq_pol),
        .irq_level (cfg_irq_level),
        .pin       (irq_pin)
    );

    // R8
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_en && cfg_irq_level) |-> (irq_pin == (crc_err_status ~^ cfg_irq_pol)));
    // R2
    no_early_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_err_status && !(frame_done && crc_fail && cfg_crc_en)) |=> !crc_err_status);
endmodule

// File: tb/crc_err_irq_mon_bench.sv
`timescale 1ns/1ps
module crc_err_irq_mon_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_done = 1'b0;
    logic       crc_fail = 1'b0;
    logic [1:0] cfg_limit = 2'd0;
    logic       cfg_crc_en = 1'b1;
    logic       cfg_irq_en = 1'b0;
    logic       cfg_irq_pol = 1'b0;
    logic       cfg_irq_level = 1'b1;
    logic       status_clr = 1'b0;
    logic       crc_err_status;
    logic       irq_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    crc_err_irq_mon u_crc_err_irq_mon (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_done     (frame_done),
        .crc_fail       (crc_fail),
        .cfg_limit      (cfg_limit),
        .cfg_crc_en     (cfg_crc_en),
        .cfg_irq_en     (cfg_irq_en),
        .cfg_irq_pol    (cfg_irq_pol),
        .cfg_irq_level  (cfg_irq_level),
        .status_clr     (status_clr),
        .crc_err_status (crc_err_status),
        .irq_pin        (irq_pin)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One frame strobe driven on a falling edge, returns on the next falling edge
    task automatic frame(input logic fail);
        frame_done = 1'b1;
        crc_fail   = fail;
        @(negedge clk);
        frame_done = 1'b0;
        crc_fail   = 1'b0;
    endtask

    task automatic clear_all();
        status_clr = 1'b1;
        cfg_crc_en = 1'b1;
        frame_done = 1'b1;
        crc_fail   = 1'b0;
        @(negedge clk);
        status_clr = 1'b0;
        frame_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status after reset", crc_err_status, 1'b0);
        check("R1 pin idle after reset", irq_pin, 1'b1);
    endtask

    task automatic t_limits();
        for (int c = 0; c < 4; c++) begin
            int n;
            n = 1 << c;
            cfg_limit = 2'(c);
            clear_all();
            for (int i = 0; i < n - 1; i++) frame(1'b1);
            check($sformatf("R2 code %0d one frame short", c), crc_err_status, 1'b0);
            frame(1'b1);
            check($sformatf("R2 code %0d at limit", c), crc_err_status, 1'b1);
        end
    endtask

    task automatic t_pass_resets();
        cfg_limit = 2'd2;
        clear_all();
        frame(1'b1); frame(1'b1); frame(1'b1);
        frame(1'b0);
        frame(1'b1); frame(1'b1); frame(1'b1);
        check("R3 pass frame empties run", crc_err_status, 1'b0);
        frame(1'b1);
        check("R3 run counted afresh", crc_err_status, 1'b1);
    endtask

    task automatic t_disable();
        cfg_limit = 2'd1;
        clear_all();
        frame(1'b1);
        cfg_crc_en = 1'b0;
        frame(1'b1); frame(1'b0); frame(1'b1);
        check("R4 disabled frames ignored", crc_err_status, 1'b0);
        cfg_crc_en = 1'b1;
        frame(1'b1);
        check("R4 run kept through disable", crc_err_status, 1'b1);
    endtask

    task automatic t_sticky();
        cfg_limit = 2'd0;
        clear_all();
        frame(1'b1);
        frame(1'b0);
        repeat (5) @(negedge clk);
        check("R5 status sticky", crc_err_status, 1'b1);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        check("R5 status cleared by strobe", crc_err_status, 1'b0);
    endtask

    task automatic t_clear_priority();
        cfg_limit = 2'd0;
        clear_all();
        status_clr = 1'b1;
        frame(1'b1);
        status_clr = 1'b0;
        check("R6 clear beats set", crc_err_status, 1'b0);
        @(negedge clk);
        check("R6 stays clear", crc_err_status, 1'b0);
    endtask

    task automatic t_saturate();
        cfg_limit = 2'd2;
        clear_all();
        repeat (6) frame(1'b1);
        check("R7 set after overrun", crc_err_status, 1'b1);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        frame(1'b1);
        check("R7 saturated run re-flags", crc_err_status, 1'b1);
    endtask

    task automatic t_level();
        cfg_limit = 2'd0; cfg_irq_en = 1'b1; cfg_irq_level = 1'b1; cfg_irq_pol = 1'b1;
        clear_all();
        check("R8 level pin idle", irq_pin, 1'b0);
        frame(1'b1);
        check("R8 level pin active", irq_pin, 1'b1);
        repeat (3) @(negedge clk);
        check("R8 level pin held", irq_pin, 1'b1);
        clear_all();
        check("R8 level pin released", irq_pin, 1'b0);
    endtask

    task automatic t_edge();
        cfg_limit = 2'd0; cfg_irq_en = 1'b1; cfg_irq_level = 1'b0; cfg_irq_pol = 1'b1;
        clear_all();
        frame(1'b1);
        check("R9 edge pulse", irq_pin, 1'b1);
        @(negedge clk);
        check("R9 pulse one cycle", irq_pin, 1'b0);
        check("R9 status still set", crc_err_status, 1'b1);
        frame(1'b1);
        check("R9 no pulse while held", irq_pin, 1'b0);
    endtask

    task automatic t_polarity();
        cfg_limit = 2'd0; cfg_irq_en = 1'b1; cfg_irq_level = 1'b1; cfg_irq_pol = 1'b0;
        clear_all();
        check("R10 low-active idle", irq_pin, 1'b1);
        frame(1'b1);
        check("R10 low-active asserted", irq_pin, 1'b0);
        cfg_irq_pol = 1'b1;
        #1;
        check("R10 high-active asserted", irq_pin, 1'b1);
    endtask

    task automatic t_irq_off();
        cfg_limit = 2'd0; cfg_irq_en = 1'b0; cfg_irq_level = 1'b1; cfg_irq_pol = 1'b1;
        clear_all();
        frame(1'b1);
        check("R11 status set", crc_err_status, 1'b1);
        check("R11 pin idle high-active", irq_pin, 1'b0);
        cfg_irq_pol = 1'b0;
        #1;
        check("R11 pin idle low-active", irq_pin, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_limits();
        t_pass_resets();
        t_disable();
        t_sticky();
        t_clear_priority();
        t_saturate();
        t_level();
        t_edge();
        t_polarity();
        t_irq_off();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule